// File: doc/BRIEF.md
# Multidrop Addressed Serial Register Port

This block is the serial slave end of a shared half-duplex bus that carries several stations. A host sends an address character, then a register character, and then either one data byte for a write or nothing for a read. The port converts these characters into a single strobe toward a local register file. For a read it sends back the register value one byte at a time, least significant byte first. While it sends, it raises a transmit-enable output, so that an external line driver can take the bus.

A character has a start bit, eight data bits sent LSB first, an addressing bit and a stop bit. The addressing bit marks address characters, so every station can find the start of a transaction. When the station address is 31, or when the plain-mode strap is high, the addressing bit is left out. Characters are then 10 bits long and the transaction is decoded by position. The strap also forces the station address to 0.

The register file sits outside the block. It answers combinationally for the register index that the port presents. It returns whether the register is writable, how many bytes a read returns, and the read value. The clear request is issued only after the last reply byte has left the line.

Top module: `mdrop_regport`

## Requirements
- R1: A received character is a low start bit, eight data bits LSB first, one addressing bit (addressed mode only) and a high stop bit. A character whose stop bit samples low is discarded. Transmitted characters use the same framing, with the addressing bit sent as 0.
- R2: The receiver samples each bit near its middle using 16 baud ticks per bit. A low pulse that is gone by the middle of the start bit is not taken as a character.
- R3: In addressed mode, an address character has its addressing bit set to 1. It is accepted only if data bits 4..0 equal the station address and bits 7..5 are zero. After a mismatch, every character with addressing bit 0 is ignored.
- R4: If the station address is 31 or the plain-mode strap is high, characters are 10 bits long, and the first character of each transaction is the address. The station address used is 0 when the strap is high and 31 otherwise. A mismatching address character leaves the port waiting for an address.
- R5: The register character carries the clear flag in bit 7 and the register index in bits 5..0. If bit 6 is 1, the transaction is dropped.
- R6: If the register file reports the index as writable, the next character is the data byte. It produces exactly one single-cycle strobe with write high, the index, and the data.
- R7: If the index is not writable and its read length is 1 to 3, the port gives one read strobe (write low). It then transmits that many bytes of the read value, least significant byte first, back to back. If the index is neither writable nor readable, the transaction is dropped.
- R8: A one-cycle clear request with the index follows the end of the last reply stop bit, but only for a read whose clear flag was set. A write never produces a clear request.
- R9: The transmit line idles high. Transmit enable is high from the read strobe until the last reply stop bit has ended, and low otherwise, including out of reset.
- R10: While transmit enable is high, the receive line is ignored. A character that arrives during a reply has no effect.
- R11: In addressed mode, a character with addressing bit 1 starts a new transaction from any receiving state, including while a write data byte is awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| station_addr | input | 5 | Station address (31 selects plain mode) |
| plain_strap | input | 1 | High forces plain 10-bit mode and station address 0 |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| tx_en | output | 1 | High while the port owns the bus for a reply |
| reg_strobe | output | 1 | One-cycle register access strobe |
| reg_write | output | 1 | Access direction, qualified by reg_strobe (1 = write) |
| reg_index | output | 6 | Register index of the current transaction |
| reg_clear | output | 1 | One-cycle clear request for reg_index |
| reg_wdata | output | 8 | Write data, qualified by reg_strobe and reg_write |
| rf_wr_ok | input | 1 | Register file: reg_index is writable |
| rf_rd_len | input | 2 | Register file: read length in bytes for reg_index (0 = none) |
| rf_rd_data | input | 24 | Register file: read value for reg_index |

## Verification
Reception and transmission can coincide. A host character may arrive on the receive line in the same cycles in which the port is driving a reply. The bench provokes this by sending a matching address character immediately after a read's register character, so that it overlaps the reply. It then sends a write register byte and data byte once the reply has ended. The overlap is judged correct if the reply bytes arrive intact and no second strobe appears, since an address accepted during the reply would have turned that later write into a real strobe.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;

  typedef enum logic [2:0] {
    ST_ADDR,
    ST_REG,
    ST_LOOK,
    ST_WDATA,
    ST_SEND
  } port_st_t;

  // index of the stop bit in a character, counting the start bit as 0
  function automatic logic [3:0] stop_pos(input logic plain);
    return plain ? 4'd9 : 4'd10;
  endfunction

  // serial image of a transmitted byte, bit 0 leaves the line first
  function automatic logic [10:0] tx_image(input logic [7:0] d, input logic plain);
    return {1'b1, plain, d, 1'b0};
  endfunction

  function automatic logic addr_hit(input logic [7:0] ch, input logic [4:0] own);
    return (ch[7:5] == 3'b000) && (ch[4:0] == own);
  endfunction

endpackage

// File: rtl/mdrop_baud.sv
module mdrop_baud #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx
  import mdrop_pkg::*;
#(
  parameter int OS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic       plain,
  input  logic       rxd,
  output logic       ch_valid,
  output logic [7:0] ch_data,
  output logic       ch_extra
);
  localparam int PW = $clog2(OS);
  localparam logic [PW-1:0] PH_MID  = PW'(OS / 2 - 1);
  localparam logic [PW-1:0] PH_LAST = PW'(OS - 1);

  logic          s1, s2;
  logic          busy;
  logic [PW-1:0] ph;
  logic [3:0]    bi;
  logic          ext;
  logic          at_sample;

  assign at_sample = (bi == 4'd0) ? (ph == PH_MID) : (ph == PH_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      ph       <= '0;
      bi       <= '0;
      ext      <= 1'b0;
      ch_valid <= 1'b0;
      ch_data  <= '0;
      ch_extra <= 1'b0;
    end else begin
      ch_valid <= 1'b0;
      if (!en) begin
        busy <= 1'b0;
      end else if (tick) begin
        if (!busy) begin
          if (!s2) begin
            busy <= 1'b1;
            ph   <= '0;
            bi   <= '0;
          end
        end else if (at_sample) begin
          ph <= '0;
          if (bi == 4'd0) begin
            if (s2) busy <= 1'b0;      // start bit did not hold: reject
            else    bi   <= 4'd1;
          end else if (bi == stop_pos(plain)) begin
            busy     <= 1'b0;
            ch_valid <= s2;            // low stop bit: framing error, drop
            ch_extra <= plain ? 1'b0 : ext;
          end else begin
            if (bi <= 4'd8) ch_data[3'(bi - 4'd1)] <= s2;
            else            ext <= s2;
            bi <= bi + 4'd1;
          end
        end else begin
          ph <= ph + 1'b1;
        end
      end
    end
  end

  p_stop_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ch_valid |-> $past(s2));
  p_valid_when_enabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ch_valid |-> $past(en));

endmodule

// File: rtl/mdrop_tx.sv
module mdrop_tx
  import mdrop_pkg::*;
#(
  parameter int OS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       go,
  input  logic       plain,
  input  logic [7:0] din,
  output logic       busy,
  output logic       txd,
  output logic       done
);
  localparam int PW = $clog2(OS);
  localparam logic [PW-1:0] PH_LAST = PW'(OS - 1);

  logic [10:0]   image;
  logic [PW-1:0] ph;
  logic [3:0]    bi;

  assign txd = busy ? image[bi] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      image <= '1;
      busy  <= 1'b0;
      ph    <= '0;
      bi    <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !busy) begin
        image <= tx_image(din, plain);
        busy  <= 1'b1;
        ph    <= '0;
        bi    <= '0;
      end else if (busy && tick) begin
        if (ph == PH_LAST) begin
          ph <= '0;
          if (bi == stop_pos(plain)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bi <= bi + 4'd1;
          end
        end else begin
          ph <= ph + 1'b1;
        end
      end
    end
  end

  p_go_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy);

endmodule

// File: rtl/mdrop_regport.sv
module mdrop_regport
  import mdrop_pkg::*;
#(
  parameter int CLK_HZ = 3_072_000,
  parameter int BAUD   = 19_200,
  parameter int OS     = 16,
  parameter int RD_MAX = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [4:0]            station_addr,
  input  logic                  plain_strap,
  input  logic                  rxd,
  output logic                  txd,
  output logic                  tx_en,
  output logic                  reg_strobe,
  output logic                  reg_write,
  output logic [5:0]            reg_index,
  output logic                  reg_clear,
  output logic [7:0]            reg_wdata,
  input  logic                  rf_wr_ok,
  input  logic [$clog2(RD_MAX+1)-1:0] rf_rd_len,
  input  logic [8*RD_MAX-1:0]   rf_rd_data
);
  localparam int DIV_RAW = CLK_HZ / (BAUD * OS);
  localparam int DIV     = (DIV_RAW < 1) ? 1 : DIV_RAW;
  localparam int LW      = $clog2(RD_MAX + 1);
  localparam int DW      = 8 * RD_MAX;
  localparam logic [LW-1:0] LEN_MAX = LW'(RD_MAX);

  logic          tick;
  logic          ch_valid, ch_extra;
  logic [7:0]    ch_data;
  logic          tx_busy, tx_done, tx_go;
  logic [7:0]    tx_byte;
  port_st_t      st;
  logic          plain;
  logic [4:0]    own;
  logic          addr_char;
  logic [LW-1:0] left;
  logic [DW-1:0] rd_shift;
  logic          clr_q;

  assign plain     = plain_strap || (station_addr == 5'd31);
  assign own       = plain_strap ? 5'd0 : station_addr;
  assign tx_en     = (st == ST_SEND);
  assign addr_char = ch_valid && (plain ? (st == ST_ADDR) : ch_extra);

  mdrop_baud #(.DIV(DIV)) baud_i (.clk(clk), .rst_n(rst_n), .tick(tick));

  mdrop_rx #(.OS(OS)) rx_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(!tx_en), .plain(plain),
    .rxd(rxd), .ch_valid(ch_valid), .ch_data(ch_data), .ch_extra(ch_extra)
  );

  mdrop_tx #(.OS(OS)) tx_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .go(tx_go), .plain(plain),
    .din(tx_byte), .busy(tx_busy), .txd(txd), .done(tx_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_ADDR;
      reg_strobe <= 1'b0;
      reg_write  <= 1'b0;
      reg_index  <= '0;
      reg_clear  <= 1'b0;
      reg_wdata  <= '0;
      tx_go      <= 1'b0;
      tx_byte    <= '0;
      left       <= '0;
      rd_shift   <= '0;
      clr_q      <= 1'b0;
    end else begin
      reg_strobe <= 1'b0;
      reg_clear  <= 1'b0;
      tx_go      <= 1'b0;
      case (st)
        ST_SEND: begin
          if (tx_done) begin
            if (left <= LW'(1)) begin
              st        <= ST_ADDR;
              reg_clear <= clr_q;
            end else begin
              left     <= left - 1'b1;
              tx_byte  <= rd_shift[7:0];
              rd_shift <= rd_shift >> 8;
              tx_go    <= 1'b1;
            end
          end
        end
        ST_LOOK: begin
          if (rf_wr_ok) begin
            st <= ST_WDATA;
          end else if (rf_rd_len != '0) begin
            reg_strobe <= 1'b1;
            reg_write  <= 1'b0;
            left       <= (rf_rd_len > LEN_MAX) ? LEN_MAX : rf_rd_len;
            tx_byte    <= rf_rd_data[7:0];
            rd_shift   <= rf_rd_data >> 8;
            tx_go      <= 1'b1;
            st         <= ST_SEND;
          end else begin
            st <= ST_ADDR;
          end
        end
        default: begin
          if (addr_char) begin
            st <= addr_hit(ch_data, own) ? ST_REG : ST_ADDR;
          end else if (ch_valid) begin
            if (st == ST_REG) begin
              if (ch_data[6]) begin
                st <= ST_ADDR;
              end else begin
                reg_index <= ch_data[5:0];
                clr_q     <= ch_data[7];
                st        <= ST_LOOK;
              end
            end else if (st == ST_WDATA) begin
              reg_strobe <= 1'b1;
              reg_write  <= 1'b1;
              reg_wdata  <= ch_data;
              st         <= ST_ADDR;
            end
          end
        end
      endcase
    end
  end

  p_line_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> txd);
  p_busy_in_reply_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> tx_en);
  p_no_rx_in_reply_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> !ch_valid);
  p_clear_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_clear |-> $past(tx_done));
  p_strobe_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_strobe |=> !reg_strobe);

endmodule

// File: tb/mdrop_regport_tb_top.sv
module mdrop_regport_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 614_400;
  localparam int BAUD       = 19_200;
  localparam int OS         = 16;
  localparam int BITCLK     = (CLK_HZ / (BAUD * OS)) * OS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  station_addr = 5'd5;
  logic        plain_strap = 1'b0;
  logic        rxd = 1'b1;
  logic        txd, tx_en, reg_strobe, reg_write, reg_clear;
  logic [5:0]  reg_index;
  logic [7:0]  reg_wdata;
  logic        rf_wr_ok;
  logic [1:0]  rf_rd_len;
  logic [23:0] rf_rd_data;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  bit b_plain = 0;
  logic [4:0] b_own = 5'd5;

  int strobe_cnt = 0, clr_cnt = 0, bad_txd = 0, tx_ferr = 0, rx_cnt = 0;
  logic last_w; logic [5:0] last_idx, clr_idx; logic [7:0] last_data;
  logic [7:0] rx_q [0:255];

  always #(CLK_PERIOD/2) clk = ~clk;

  // register file model
  function automatic logic b_wr(input logic [5:0] i);
    return (i >= 6'd48) && (i < 6'd60);
  endfunction
  function automatic logic [1:0] b_len(input logic [5:0] i);
    if (i >= 6'd48) return 2'd0;
    return 2'(i % 3) + 2'd1;
  endfunction
  function automatic logic [23:0] b_val(input logic [5:0] i);
    return {8'(i * 3 + 1), ~{2'b00, i}, {2'b00, i} ^ 8'hC3};
  endfunction

  assign rf_wr_ok   = b_wr(reg_index);
  assign rf_rd_len  = b_len(reg_index);
  assign rf_rd_data = b_val(reg_index);

  mdrop_regport #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .OS(OS), .RD_MAX(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .station_addr(station_addr), .plain_strap(plain_strap),
    .rxd(rxd), .txd(txd), .tx_en(tx_en), .reg_strobe(reg_strobe), .reg_write(reg_write),
    .reg_index(reg_index), .reg_clear(reg_clear), .reg_wdata(reg_wdata),
    .rf_wr_ok(rf_wr_ok), .rf_rd_len(rf_rd_len), .rf_rd_data(rf_rd_data)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_strobe) begin
        strobe_cnt++; last_w = reg_write; last_idx = reg_index; last_data = reg_wdata;
      end
      if (reg_clear) begin clr_cnt++; clr_idx = reg_index; end
      if (txd === 1'b0 && tx_en !== 1'b1) bad_txd++;
    end
  end

  // reply decoder
  initial begin
    forever begin
      logic [7:0] b; logic ex, sp;
      @(negedge txd);
      repeat (BITCLK/2) @(negedge clk);
      if (txd === 1'b0) begin
        for (int i = 0; i < 8; i++) begin repeat (BITCLK) @(negedge clk); b[i] = txd; end
        ex = 1'b0;
        if (!b_plain) begin repeat (BITCLK) @(negedge clk); ex = txd; end
        repeat (BITCLK) @(negedge clk); sp = txd;
        if (ex !== 1'b0 || sp !== 1'b1) tx_ferr++;
        rx_q[rx_cnt % 256] = b;
        rx_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send_char(input logic [7:0] d, input logic ext, input bit stop_ok);
    @(negedge clk);
    rxd = 1'b0; repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; repeat (BITCLK) @(negedge clk); end
    if (!b_plain) begin rxd = ext; repeat (BITCLK) @(negedge clk); end
    if (stop_ok) begin
      rxd = 1'b1; repeat (BITCLK) @(negedge clk);
    end else begin
      rxd = 1'b0; repeat (BITCLK*5/8) @(negedge clk);
      rxd = 1'b1; repeat (BITCLK) @(negedge clk);
    end
  endtask

  task automatic wait_reply(input int r0, input int n);
    for (int k = 0; k < 6*11*BITCLK && rx_cnt < r0 + n; k++) @(negedge clk);
    repeat (12*BITCLK) @(negedge clk);
  endtask

  task automatic txn(input logic [7:0] ab, input logic [7:0] rb, input logic [7:0] wd,
                     input bit match, input string req);
    logic [5:0] idx; bit bad, clr, exp_w; int exp_n, s0, c0, r0; logic [23:0] v;
    idx = rb[5:0]; bad = rb[6]; clr = rb[7];
    exp_w = match && !bad && b_wr(idx);
    exp_n = (match && !bad && !b_wr(idx)) ? int'(b_len(idx)) : 0;
    s0 = strobe_cnt; c0 = clr_cnt; r0 = rx_cnt; v = b_val(idx);
    send_char(ab, 1'b1, 1'b1);
    send_char(rb, 1'b0, 1'b1);
    if (!bad && b_wr(idx)) send_char(wd, 1'b0, 1'b1);
    wait_reply(r0, exp_n);
    chk(rx_cnt - r0 == exp_n, "R7", "reply byte count", rx_cnt - r0, exp_n);
    for (int k = 0; k < exp_n; k++)
      chk(rx_q[(r0 + k) % 256] == v[8*k +: 8], "R7", "reply byte value",
          int'(rx_q[(r0 + k) % 256]), int'(v[8*k +: 8]));
    chk(strobe_cnt - s0 == int'(exp_w || exp_n > 0), req, "strobe count",
        strobe_cnt - s0, int'(exp_w || exp_n > 0));
    if (exp_w)
      chk(last_w == 1'b1 && last_idx == idx && last_data == wd, "R6", "write strobe fields",
          int'({last_w, last_idx, last_data}), int'({1'b1, idx, wd}));
    if (exp_n > 0)
      chk(last_w == 1'b0 && last_idx == idx, "R7", "read strobe fields",
          int'({last_w, last_idx}), int'({1'b0, idx}));
    chk(clr_cnt - c0 == int'(exp_n > 0 && clr), "R8", "clear count",
        clr_cnt - c0, int'(exp_n > 0 && clr));
    if (exp_n > 0 && clr) chk(clr_idx == idx, "R8", "clear index", int'(clr_idx), int'(idx));
    chk(tx_en == 1'b0, "R9", "tx_en after transaction", int'(tx_en), 0);
  endtask

  task automatic rand_txns(input int n, input bit allow_miss);
    for (int t = 0; t < n; t++) begin
      logic [7:0] rb, ab; bit match; int sel;
      rb = {1'($urandom % 2), ($urandom % 8 == 0) ? 1'b1 : 1'b0, 6'($urandom % 64)};
      sel = allow_miss ? int'($urandom % 6) : 5;
      match = (sel >= 2);
      if (sel == 0)      ab = {3'b000, 5'((int'(b_own) + 1 + int'($urandom % 29)) % 31)};
      else if (sel == 1) ab = {3'b010, b_own};
      else               ab = {3'b000, b_own};
      txn(ab, rb, 8'($urandom), match, allow_miss ? "R3" : "R4");
    end
  endtask

  initial begin
    int s0, r0;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(txd == 1'b1 && tx_en == 1'b0, "R9", "line after reset", int'({txd, tx_en}), 2);
    chk(reg_strobe == 1'b0 && reg_clear == 1'b0, "R9", "strobes after reset",
        int'({reg_strobe, reg_clear}), 0);

    // addressed mode, station 5
    txn(8'd5, 8'h82, 8'h00, 1, "R7");          // read 3 bytes with clear
    txn(8'd5, 8'hB2, 8'hA7, 1, "R8");          // write idx 50 with clear flag: no clear
    txn(8'd5, 8'h01, 8'h00, 1, "R7");          // read 2 bytes
    txn(8'd5, 8'h00, 8'h00, 1, "R7");          // read 1 byte
    txn(8'd6, 8'h01, 8'h00, 0, "R3");          // other station
    txn(8'h25, 8'h01, 8'h00, 0, "R3");         // high bits set
    txn(8'd5, 8'h41, 8'h00, 0, "R5");          // bit 6 set
    txn(8'd5, 8'h3D, 8'h00, 0, "R7");          // idx 61: neither
    // R11: address character while awaiting write data restarts
    send_char(8'd5, 1'b1, 1'b1);
    send_char(8'd50, 1'b0, 1'b1);
    txn(8'd5, 8'h05, 8'h00, 1, "R11");
    // R2: short low pulse between address and register characters
    s0 = strobe_cnt; r0 = rx_cnt;
    send_char(8'd5, 1'b1, 1'b1);
    @(negedge clk); rxd = 1'b0; repeat (6) @(negedge clk); rxd = 1'b1;
    repeat (12*BITCLK) @(negedge clk);
    send_char(8'h02, 1'b0, 1'b1);
    wait_reply(r0, 3);
    chk(rx_cnt - r0 == 3, "R2", "reply after glitch", rx_cnt - r0, 3);
    chk(strobe_cnt - s0 == 1, "R2", "strobe after glitch", strobe_cnt - s0, 1);
    // R1: address character with a low stop bit is dropped
    s0 = strobe_cnt; r0 = rx_cnt;
    send_char(8'd5, 1'b1, 1'b0);
    send_char(8'h02, 1'b0, 1'b1);
    wait_reply(r0, 0);
    chk(rx_cnt - r0 == 0, "R1", "reply after bad stop", rx_cnt - r0, 0);
    chk(strobe_cnt - s0 == 0, "R1", "strobe after bad stop", strobe_cnt - s0, 0);
    // R10: address character overlapping a reply is ignored
    s0 = strobe_cnt; r0 = rx_cnt;
    send_char(8'd5, 1'b1, 1'b1);
    send_char(8'h01, 1'b0, 1'b1);
    send_char(8'd5, 1'b1, 1'b1);
    wait_reply(r0, 2);
    send_char(8'd50, 1'b0, 1'b1);
    send_char(8'h3C, 1'b0, 1'b1);
    repeat (12*BITCLK) @(negedge clk);
    chk(rx_cnt - r0 == 2, "R10", "reply during overlap", rx_cnt - r0, 2);
    chk(strobe_cnt - s0 == 1, "R10", "strobes after overlap", strobe_cnt - s0, 1);
    rand_txns(10, 1);

    // plain mode through station 31
    station_addr = 5'd31; b_plain = 1; b_own = 5'd31;
    repeat (4*BITCLK) @(negedge clk);
    txn(8'd31, 8'h85, 8'h00, 1, "R4");
    txn(8'd31, 8'h37, 8'h5A, 1, "R4");
    rand_txns(8, 0);

    // plain mode through the strap, address forced to 0
    station_addr = 5'd9; plain_strap = 1'b1; b_own = 5'd0;
    repeat (4*BITCLK) @(negedge clk);
    txn(8'd0, 8'h88, 8'h00, 1, "R4");
    rand_txns(6, 0);

    chk(bad_txd == 0, "R9", "txd low without tx_en cycles", bad_txd, 0);
    chk(tx_ferr == 0, "R1", "reply framing errors", tx_ferr, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R7 watchdog actual=%0d expected=%0d", 190000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule